// File: doc/BRIEF.md
# Correlation Peak Selector and Despread Bit Extractor

This block sits behind a block correlator in a spread-spectrum receiver. For each symbol section the correlator announces that a fresh set of complex correlation lags is ready, then streams one lag per cycle. The block stores the sixteen in-phase/quadrature pairs and computes the squared magnitude of each one. It runs both components of a lag through a single shared squaring table, which takes four cycles per lag. It keeps a running maximum together with the index of the lag that produced it.

Once every lag has been scanned, the block reads the signs of the stored in-phase and quadrature values at the winning lag. The in-phase sign is the despread data bit and the quadrature sign is the despread pilot bit. A counter tracks the symbols of an eight-symbol block, and a completion pulse tells the correlator that it may move on to its next block of chips. Control is a five-state sequence: idle, load, square, compare and emit.

Top module: `corr_peak_ctrl`

## Requirements
- R1: After reset, `bit_valid`, `block_done`, `data_bit` and `pilot_bit` are all 0 and the controller is idle.
- R2: The controller leaves idle only on a clock edge at which `lag_ready` is 1. While `lag_ready` stays 0, no result is produced. A `lag_ready` pulse that arrives while a section is being processed has no effect: it produces no extra result and does not change the timing of the current result.
- R3: If `lag_ready` is sampled at edge E, then lag m (m = 0..15) is captured from `lag_re`/`lag_im` at edge E+1+m. Values present on any other edge are not stored.
- R4: The magnitude of a lag is re² + im², computed over the full signed 8-bit range (for example, -128 gives 16384). Both components contribute to it.
- R5: A lag replaces the stored maximum only if its magnitude is strictly greater than that maximum. The maximum is cleared to 0 at the start of every section, so lag 0 wins a tie, and an all-zero section selects lag 0. A section's result never depends on the magnitudes of earlier sections.
- R6: `data_bit` is 1 exactly when the stored in-phase value at the winning lag is negative, and `pilot_bit` is 1 exactly when the stored quadrature value there is negative. Both hold their values until the next result.
- R7: `bit_valid` is a one-cycle pulse that is high in the cycle after edge E+97 (in general E+1+6N for N lags). Each lag takes four squaring cycles and one compare cycle.
- R8: `block_done` pulses together with every eighth `bit_valid` counted from reset, and is 0 with all other results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lag_ready | input | 1 | New lag set follows; sampled only while idle |
| lag_re | input | 8 | In-phase correlation lag, signed |
| lag_im | input | 8 | Quadrature correlation lag, signed |
| data_bit | output | 1 | Despread data bit (1 = negative in-phase peak) |
| pilot_bit | output | 1 | Despread pilot bit (1 = negative quadrature peak) |
| bit_valid | output | 1 | One-cycle strobe marking a new bit pair |
| block_done | output | 1 | One-cycle strobe with the last symbol of a block |

## Verification
A section's result appears 97 edges after the edge that samples `lag_ready`. Lags are captured on the sixteen edges that directly follow that edge. The bench drives every input on the falling edge and counts falling edges from the request. It checks that `bit_valid` is still low after edge 96, high with the expected bits and block flag after edge 97, and low again after edge 98. Stray requests are placed in the middle of processing, and the output is then watched for more than a full section length, so a late or duplicated result would be caught.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int PK_LAG_W    = 8;
  localparam int PK_NUM_LAGS = 16;
  localparam int PK_SYMS     = 8;
  localparam int PK_SQ_CYC   = 4;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_LOAD    = 3'd1,
    S_SQUARE  = 3'd2,
    S_COMPARE = 3'd3,
    S_EMIT    = 3'd4
  } pk_state_e;
endpackage

// File: rtl/pk_lag_store.sv
module pk_lag_store #(
  parameter int LAG_W    = 8,
  parameter int NUM_LAGS = 16,
  localparam int IDX_W   = $clog2(NUM_LAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LAG_W-1:0] wr_re,
  input  logic [LAG_W-1:0] wr_im,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LAG_W-1:0] rd_re,
  output logic [LAG_W-1:0] rd_im,
  input  logic [IDX_W-1:0] sg_idx,
  output logic             sg_re,
  output logic             sg_im
);
  logic [LAG_W-1:0] re_arr [NUM_LAGS];
  logic [LAG_W-1:0] im_arr [NUM_LAGS];

  for (genvar e = 0; e < NUM_LAGS; e++) begin : g_entry
    logic [LAG_W-1:0] re_r;
    logic [LAG_W-1:0] im_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        re_r <= '0;
        im_r <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        re_r <= wr_re;
        im_r <= wr_im;
      end
    end
    assign re_arr[e] = re_r;
    assign im_arr[e] = im_r;
  end

  assign rd_re = re_arr[rd_idx];
  assign rd_im = im_arr[rd_idx];
  // sign bits of the winning pair
  assign sg_re = re_arr[sg_idx][LAG_W-1];
  assign sg_im = im_arr[sg_idx][LAG_W-1];
endmodule

// File: rtl/pk_square_unit.sv
module pk_square_unit #(
  parameter int LAG_W   = 8,
  localparam int SQ_W   = 2*LAG_W-1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LAG_W-1:0] x,
  output logic [SQ_W-1:0]  sq
);
  // shared squaring table, written as the function it tabulates
  function automatic logic [SQ_W-1:0] square_of(input logic [LAG_W-1:0] v);
    logic [LAG_W-1:0]   a;
    logic [2*LAG_W-1:0] p;
    a = v[LAG_W-1] ? (~v + 1'b1) : v;
    p = {{LAG_W{1'b0}}, a} * {{LAG_W{1'b0}}, a};
    return p[SQ_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sq <= '0;
    else if (en) sq <= square_of(x);
  end
endmodule

// File: rtl/pk_peak_track.sv
module pk_peak_track #(
  parameter int MAG_W    = 16,
  parameter int NUM_LAGS = 16,
  localparam int IDX_W   = $clog2(NUM_LAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [MAG_W-1:0] mag,
  input  logic [IDX_W-1:0] idx,
  output logic             win,
  output logic [MAG_W-1:0] max_q,
  output logic [IDX_W-1:0] best_q
);
  assign win = upd && (mag > max_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q  <= '0;
      best_q <= '0;
    end else if (clr) begin
      max_q  <= '0;
      best_q <= '0;
    end else if (win) begin
      max_q  <= mag;
      best_q <= idx;
    end
  end
endmodule

// File: rtl/corr_peak_ctrl.sv
module corr_peak_ctrl
  import pk_pkg::*;
#(
  parameter int LAG_W    = PK_LAG_W,
  parameter int NUM_LAGS = PK_NUM_LAGS,
  parameter int SYMS     = PK_SYMS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lag_ready,
  input  logic [LAG_W-1:0] lag_re,
  input  logic [LAG_W-1:0] lag_im,
  output logic             data_bit,
  output logic             pilot_bit,
  output logic             bit_valid,
  output logic             block_done
);
  localparam int IDX_W = $clog2(NUM_LAGS);
  localparam int SQ_W  = 2*LAG_W-1;
  localparam int MAG_W = SQ_W+1;
  localparam int CNT_W = $clog2(PK_SQ_CYC);
  localparam int SYM_W = (SYMS > 1) ? $clog2(SYMS) : 1;

  pk_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] sq_cnt_q;
  logic [SYM_W-1:0] sym_q;
  logic [MAG_W-1:0] mag_q;

  // named internal events
  logic idx_last, sq_last, sym_last, start_sec, cmp_fire, win;
  logic [LAG_W-1:0] rd_re, rd_im, sq_in;
  logic [SQ_W-1:0]  sq_val;
  logic [MAG_W-1:0] max_q;
  logic [IDX_W-1:0] best_q;
  logic             sg_re, sg_im;

  assign idx_last  = (idx_q == IDX_W'(NUM_LAGS-1));
  assign sq_last   = (sq_cnt_q == CNT_W'(PK_SQ_CYC-1));
  assign sym_last  = (sym_q == SYM_W'(SYMS-1));
  assign start_sec = (state_q == S_IDLE) && lag_ready;
  assign cmp_fire  = (state_q == S_COMPARE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (lag_ready) state_d = S_LOAD;
      S_LOAD:    if (idx_last)  state_d = S_SQUARE;
      S_SQUARE:  if (sq_last)   state_d = S_COMPARE;
      S_COMPARE: state_d = idx_last ? S_EMIT : S_SQUARE;
      S_EMIT:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // lag index: write pointer during load, scan pointer afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (state_q == S_LOAD || state_q == S_COMPARE)
      idx_q <= idx_last ? '0 : idx_q + 1'b1;
    else if (state_q == S_IDLE)
      idx_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_cnt_q <= '0;
    else if (state_q == S_SQUARE) sq_cnt_q <= sq_last ? '0 : sq_cnt_q + 1'b1;
    else sq_cnt_q <= '0;
  end

  pk_lag_store #(.LAG_W(LAG_W), .NUM_LAGS(NUM_LAGS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(state_q == S_LOAD), .wr_idx(idx_q), .wr_re(lag_re), .wr_im(lag_im),
    .rd_idx(idx_q), .rd_re(rd_re), .rd_im(rd_im),
    .sg_idx(best_q), .sg_re(sg_re), .sg_im(sg_im)
  );

  // first squaring slot takes the in-phase value, the rest the quadrature
  assign sq_in = (sq_cnt_q == '0) ? rd_re : rd_im;

  pk_square_unit #(.LAG_W(LAG_W)) u_square (
    .clk(clk), .rst_n(rst_n), .en(state_q == S_SQUARE), .x(sq_in), .sq(sq_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mag_q <= '0;
    else if (state_q == S_SQUARE) begin
      if (sq_cnt_q == CNT_W'(1))      mag_q <= {1'b0, sq_val};
      else if (sq_cnt_q == CNT_W'(2)) mag_q <= mag_q + {1'b0, sq_val};
    end
  end

  pk_peak_track #(.MAG_W(MAG_W), .NUM_LAGS(NUM_LAGS)) u_peak (
    .clk(clk), .rst_n(rst_n), .clr(start_sec), .upd(cmp_fire),
    .mag(mag_q), .idx(idx_q), .win(win), .max_q(max_q), .best_q(best_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_bit   <= 1'b0;
      pilot_bit  <= 1'b0;
      bit_valid  <= 1'b0;
      block_done <= 1'b0;
      sym_q      <= '0;
    end else if (state_q == S_EMIT) begin
      data_bit   <= sg_re;
      pilot_bit  <= sg_im;
      bit_valid  <= 1'b1;
      block_done <= sym_last;
      sym_q      <= sym_last ? '0 : sym_q + 1'b1;
    end else begin
      bit_valid  <= 1'b0;
      block_done <= 1'b0;
    end
  end
endmodule

// File: rtl/pk_checker.sv
module pk_checker
  import pk_pkg::*;
#(
  parameter int MAG_W = 16,
  parameter int IDX_W = 4,
  parameter int SYMS  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input pk_state_e        state_q,
  input logic             lag_ready,
  input logic             win,
  input logic             cmp_fire,
  input logic [MAG_W-1:0] max_q,
  input logic [IDX_W-1:0] best_q,
  input logic [IDX_W-1:0] idx_q,
  input logic             bit_valid,
  input logic             block_done
);
  localparam int VC_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  logic [VC_W-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (bit_valid) vcnt <= (vcnt == VC_W'(SYMS-1)) ? '0 : vcnt + 1'b1;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !lag_ready) |=> (state_q == S_IDLE));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R7
  square_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COMPARE) |-> ($past(state_q, 1) == S_SQUARE && $past(state_q, 4) == S_SQUARE));

  // R5
  win_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> (best_q == $past(idx_q)));

  // R5
  no_win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !win) |=> $stable(max_q));

  // R8
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (bit_valid && vcnt == VC_W'(SYMS-1)));

  // R8
  done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && vcnt == VC_W'(SYMS-1)) |-> block_done);
endmodule

bind corr_peak_ctrl pk_checker #(.MAG_W(MAG_W), .IDX_W(IDX_W), .SYMS(SYMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .lag_ready(lag_ready),
  .win(win), .cmp_fire(cmp_fire), .max_q(max_q), .best_q(best_q), .idx_q(idx_q),
  .bit_valid(bit_valid), .block_done(block_done)
);

// File: tb/corr_peak_ctrl_test.sv
module corr_peak_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lag_ready = 1'b0;
  logic [7:0] lag_re = '0;
  logic [7:0] lag_im = '0;
  logic data_bit, pilot_bit, bit_valid, block_done;

  int checks = 0;
  int fails = 0;
  int syms_seen = 0;
  bit finished = 1'b0;

  logic signed [7:0] tre [16];
  logic signed [7:0] tim [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_peak_ctrl uut (
    .clk(clk), .rst_n(rst_n), .lag_ready(lag_ready), .lag_re(lag_re), .lag_im(lag_im),
    .data_bit(data_bit), .pilot_bit(pilot_bit), .bit_valid(bit_valid), .block_done(block_done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_pattern();
    for (int m = 0; m < 16; m++) begin
      tre[m] = 8'sd0;
      tim[m] = 8'sd0;
    end
  endtask

  // one section: request, 16 lags, then timed result checks (R3, R5, R6, R7, R8)
  task automatic run_sym(input string tag, input bit busy_pulse);
    int best, mx, mg;
    bit exp_d, exp_p, exp_done;
    best = 0; mx = 0;
    for (int m = 0; m < 16; m++) begin
      mg = int'(tre[m]) * int'(tre[m]) + int'(tim[m]) * int'(tim[m]);
      if (mg > mx) begin mx = mg; best = m; end
    end
    exp_d = tre[best] < 0;
    exp_p = tim[best] < 0;
    syms_seen++;
    exp_done = (syms_seen % 8) == 0;

    @(negedge clk); lag_ready = 1'b1; lag_re = '0; lag_im = '0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      lag_ready = 1'b0;
      lag_re = tre[m];
      lag_im = tim[m];
    end
    @(negedge clk); lag_re = '0; lag_im = '0;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      lag_ready = busy_pulse && (k == 30);
      lag_re = 8'h7f; lag_im = 8'h80;  // junk off the capture window (R3)
    end
    lag_ready = 1'b0;
    check(bit_valid == 1'b0, "R7", {tag, " early valid"}, int'(bit_valid), 0);
    @(negedge clk);
    check(bit_valid == 1'b1, "R7", {tag, " valid due"}, int'(bit_valid), 1);
    check(data_bit == exp_d, "R6", {tag, " data_bit"}, int'(data_bit), int'(exp_d));
    check(pilot_bit == exp_p, "R6", {tag, " pilot_bit"}, int'(pilot_bit), int'(exp_p));
    check(block_done == exp_done, "R8", {tag, " block_done"}, int'(block_done), int'(exp_done));
    @(negedge clk);
    check(bit_valid == 1'b0 && block_done == 1'b0, "R7", {tag, " pulse width"},
          int'(bit_valid) + int'(block_done), 0);
    lag_re = '0; lag_im = '0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({data_bit, pilot_bit, bit_valid, block_done} == 4'b0, "R1", "outputs in reset",
          int'({data_bit, pilot_bit, bit_valid, block_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({data_bit, pilot_bit, bit_valid, block_done} == 4'b0, "R1", "outputs after reset",
          int'({data_bit, pilot_bit, bit_valid, block_done}), 0);
  endtask

  task automatic test_idle();
    int seen = 0;
    lag_re = 8'h40; lag_im = 8'hc0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (bit_valid) seen++;
    end
    check(seen == 0, "R2", "no result while idle", seen, 0);
    lag_re = '0; lag_im = '0;
  endtask

  task automatic test_basic();
    clear_pattern();
    tre[5] = -8'sd40; tim[5] = 8'sd30;
    tre[6] = 8'sd20;  tim[6] = 8'sd20;
    run_sym("R3 basic peak", 1'b0);
  endtask

  task automatic test_edges();
    clear_pattern();
    tre[15] = -8'sd50; tim[15] = -8'sd50;
    run_sym("R3 last lag", 1'b0);
    clear_pattern();
    tre[0] = 8'sd60; tim[0] = -8'sd60;
    tre[1] = -8'sd10;
    run_sym("R3 first lag", 1'b0);
  endtask

  task automatic test_tie();
    clear_pattern();
    tre[3] = 8'sd30;  tim[3] = 8'sd40;
    tre[9] = -8'sd40; tim[9] = -8'sd30;
    run_sym("R5 tie lowest", 1'b0);
    clear_pattern();
    run_sym("R5 all zero", 1'b0);
  endtask

  task automatic test_magnitude();
    clear_pattern();
    tre[2] = 8'sd100; tim[2] = 8'sd100;
    tre[12] = -8'sd128; tim[12] = -8'sd128;
    run_sym("R4 full range", 1'b0);
    clear_pattern();
    tre[4] = -8'sd90; tim[4] = 8'sd0;
    tre[8] = 8'sd64;  tim[8] = -8'sd64;
    run_sym("R4 both parts", 1'b0);
  endtask

  task automatic test_busy();
    int seen = 0;
    clear_pattern();
    tre[7] = -8'sd70; tim[7] = 8'sd5;
    run_sym("R2 busy request", 1'b1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (bit_valid) seen++;
    end
    check(seen == 0, "R2", "busy request ignored", seen, 0);
  endtask

  task automatic test_fresh_max();
    clear_pattern();
    tre[10] = 8'sd3; tim[10] = -8'sd2;
    tre[11] = -8'sd1; tim[11] = 8'sd1;
    run_sym("R5 fresh maximum", 1'b0);
  endtask

  task automatic test_block();
    for (int s = 0; s < 8; s++) begin
      clear_pattern();
      tre[(s*5) % 16] = (s % 2) ? -8'sd25 : 8'sd25;
      tim[(s*5) % 16] = (s % 3 == 0) ? -8'sd15 : 8'sd15;
      tre[(s*5 + 1) % 16] = 8'sd12;
      run_sym("R8 block run", 1'b0);
    end
  endtask

  initial begin
    test_reset();
    test_idle();
    test_basic();
    test_edges();
    test_tie();
    test_magnitude();
    test_busy();
    test_fresh_max();
    test_block();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule